// File: doc/BRIEF.md
# Comparator Control and Edge-Flag Logic

This block is the digital side of an analog voltage comparator. The comparator output arrives with no timing relation to the system clock. The block passes it through a multi-flop synchronizer and presents the result as a status level. While the comparator is enabled, the block watches that level for transitions. Each rising transition sets one flag and each falling transition sets another. A flag holds until software clears it. Together with per-flag enables, the flags form a single interrupt request.

Software reaches the block through a small write port with two registers. The control register holds the enable bit, the two hysteresis codes (one for the positive side, one for the negative side) and the clear controls for the flags. The mode register holds the response-time code and the two interrupt enables. The block does not interpret the hysteresis or response-time codes; it stores them and drives them to the analog circuit. While the comparator is enabled and its output is low, the block also asserts a wake request toward the internal oscillator.

Top module: `cmp_ctrl_top`

## Requirements
- R1: A high-to-low transition of `cmp_level` while enabled sets `fall_flag` on the clock edge after `cmp_level` changes. That is the third rising clock edge after `cmp_async` changes.
- R2: A low-to-high transition of `cmp_level` while enabled sets `rise_flag` on the clock edge after `cmp_level` changes.
- R3: Both flags are sticky. Hardware never clears them. A write to address 0 with bit 5 equal to 0 clears `rise_flag`, and bit 4 equal to 0 clears `fall_flag`. Writing 1 to either bit leaves that flag unchanged.
- R4: A clear and a new edge of the same kind on the same clock edge leave that flag set.
- R5: `cmp_level` follows `cmp_async` through a two-stage synchronizer. It changes on the second rising edge after the input changes, and it is valid whether or not the comparator is enabled.
- R6: `cmp_en` is bit 7 of address 0. While it is 0, no flag is set. When it changes from 0 to 1, a level that differs from the level seen earlier does not set a flag.
- R7: `wake_req` is 1 one clock after `cmp_en` is 1 and `cmp_level` is 0, and is 0 otherwise.
- R8: At address 0, bits 3:2 set `hyst_pos` and bits 1:0 set `hyst_neg`. Each is a two-bit code from 0 to 3. Both hold their value when no write occurs.
- R9: At address 1, bits 1:0 set `resp_mode`, bit 5 enables the rising-flag interrupt and bit 4 enables the falling-flag interrupt.
- R10: `irq` is 1 one clock after either (`rise_flag` and its enable) or (`fall_flag` and its enable) is true.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_async | input | 1 | Raw comparator output, asynchronous |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | Register select: 0 control, 1 mode |
| wr_data | input | 8 | Write data |
| cmp_en | output | 1 | Comparator enable to the analog side |
| hyst_pos | output | 2 | Positive hysteresis code |
| hyst_neg | output | 2 | Negative hysteresis code |
| resp_mode | output | 2 | Response-time code |
| cmp_level | output | 1 | Synchronized comparator level |
| rise_flag | output | 1 | Sticky rising-edge flag |
| fall_flag | output | 1 | Sticky falling-edge flag |
| irq | output | 1 | Interrupt request |
| wake_req | output | 1 | Oscillator wake request |

## Verification
The bench drives inputs on falling clock edges and counts the rising edges before each result is due. Register fields are due one edge after the write and `wake_req` one edge after that. `cmp_level` is due two edges after the input changes, a flag three edges after, and `irq` four edges after. Each check samples on a falling edge exactly at that count. For a flag, the bench first confirms that it is still clear one edge earlier, so a flag that arrives early or late is reported. To test that a clear and a new edge on the same clock edge leave the flag set, the bench times the clearing write to land on the edge where the new flag is due.

// File: rtl/cmp_ctrl_pkg.sv
package cmp_ctrl_pkg;
  localparam int DATA_W  = 8;
  localparam int CODE_W  = 2;
  localparam int ADDR_W  = 1;

  // control register (address 0) bit positions
  localparam int CTL_EN_BIT   = 7;
  localparam int CTL_RCLR_BIT = 5;
  localparam int CTL_FCLR_BIT = 4;
  localparam int CTL_HPOS_LSB = 2;
  localparam int CTL_HNEG_LSB = 0;

  // mode register (address 1) bit positions
  localparam int MOD_RIE_BIT  = 5;
  localparam int MOD_FIE_BIT  = 4;
  localparam int MOD_RESP_LSB = 0;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL = 1'b0,
    REG_MODE = 1'b1
  } reg_sel_e;

  typedef struct packed {
    logic              en;
    logic [CODE_W-1:0] hpos;
    logic [CODE_W-1:0] hneg;
    logic [CODE_W-1:0] resp;
    logic              rie;
    logic              fie;
  } cmp_cfg_t;
endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= d;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/cmp_regs.sv
module cmp_regs
  import cmp_ctrl_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output cmp_cfg_t          cfg,
  output logic              clr_rise,
  output logic              clr_fall
);
  logic ctl_wr, mod_wr;
  logic wr_data_unused;

  assign ctl_wr = wr_en && (wr_addr == REG_CTRL);
  assign mod_wr = wr_en && (wr_addr == REG_MODE);
  assign wr_data_unused = ^wr_data;

  // writing 0 to a flag position clears it; writing 1 leaves it alone
  assign clr_rise = ctl_wr && !wr_data[CTL_RCLR_BIT];
  assign clr_fall = ctl_wr && !wr_data[CTL_FCLR_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0;
    end else begin
      if (ctl_wr) begin
        cfg.en   <= wr_data[CTL_EN_BIT];
        cfg.hpos <= wr_data[CTL_HPOS_LSB +: CODE_W];
        cfg.hneg <= wr_data[CTL_HNEG_LSB +: CODE_W];
      end
      if (mod_wr) begin
        cfg.resp <= wr_data[MOD_RESP_LSB +: CODE_W];
        cfg.rie  <= wr_data[MOD_RIE_BIT];
        cfg.fie  <= wr_data[MOD_FIE_BIT];
      end
    end
  end

  AST_HYST_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(cfg.hpos) && $stable(cfg.hneg) && $stable(cfg.en))); // R8

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(cfg.resp) && $stable(cfg.rie) && $stable(cfg.fie))); // R9
endmodule

// File: rtl/cmp_edge_flags.sv
module cmp_edge_flags #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  input  logic enable,
  input  logic clr_rise,
  input  logic clr_fall,
  output logic level,
  output logic rise_flag,
  output logic fall_flag
);
  logic hist;
  logic rise_hit, fall_hit;

  cmp_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk (clk),
    .rst (rst),
    .d   (async_in),
    .q   (level)
  );

  // history tracks the level at all times, so enabling never compares
  // against a stale value
  always_ff @(posedge clk) begin
    if (rst) hist <= 1'b0;
    else     hist <= level;
  end

  assign rise_hit = enable &&  level && !hist;
  assign fall_hit = enable && !level &&  hist;

  // a new edge takes priority over a software clear
  always_ff @(posedge clk) begin
    if (rst) begin
      rise_flag <= 1'b0;
      fall_flag <= 1'b0;
    end else begin
      rise_flag <= rise_hit | (rise_flag & ~clr_rise);
      fall_flag <= fall_hit | (fall_flag & ~clr_fall);
    end
  end

  AST_FALL_SET: assert property (@(posedge clk) disable iff (rst)
    (enable && $fell(level)) |=> fall_flag); // R1

  AST_RISE_SET: assert property (@(posedge clk) disable iff (rst)
    (enable && $rose(level)) |=> rise_flag); // R2

  AST_RISE_STICKY: assert property (@(posedge clk) disable iff (rst)
    (rise_flag && !clr_rise) |=> rise_flag); // R3

  AST_FALL_STICKY: assert property (@(posedge clk) disable iff (rst)
    (fall_flag && !clr_fall) |=> fall_flag); // R3

  AST_NO_SET_OFF: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!$rose(rise_flag) && !$rose(fall_flag))); // R6
endmodule

// File: rtl/cmp_ctrl_top.sv
module cmp_ctrl_top
  import cmp_ctrl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmp_async,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              cmp_en,
  output logic [CODE_W-1:0] hyst_pos,
  output logic [CODE_W-1:0] hyst_neg,
  output logic [CODE_W-1:0] resp_mode,
  output logic              cmp_level,
  output logic              rise_flag,
  output logic              fall_flag,
  output logic              irq,
  output logic              wake_req
);
  cmp_cfg_t cfg;
  logic     clr_rise, clr_fall;

  cmp_regs i_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .cfg      (cfg),
    .clr_rise (clr_rise),
    .clr_fall (clr_fall)
  );

  cmp_edge_flags #(.SYNC_STAGES(SYNC_STAGES)) i_edges (
    .clk       (clk),
    .rst       (rst),
    .async_in  (cmp_async),
    .enable    (cfg.en),
    .clr_rise  (clr_rise),
    .clr_fall  (clr_fall),
    .level     (cmp_level),
    .rise_flag (rise_flag),
    .fall_flag (fall_flag)
  );

  assign cmp_en    = cfg.en;
  assign hyst_pos  = cfg.hpos;
  assign hyst_neg  = cfg.hneg;
  assign resp_mode = cfg.resp;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq      <= 1'b0;
      wake_req <= 1'b0;
    end else begin
      irq      <= (rise_flag & cfg.rie) | (fall_flag & cfg.fie);
      wake_req <= cfg.en & ~cmp_level;
    end
  end

  AST_WAKE_LOW: assert property (@(posedge clk) disable iff (rst)
    (cmp_en && !cmp_level) |=> wake_req); // R7

  AST_WAKE_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!cmp_en || cmp_level) |=> !wake_req); // R7

  AST_IRQ_SRC: assert property (@(posedge clk) disable iff (rst)
    (!rise_flag && !fall_flag) |=> !irq); // R10
endmodule

// File: tb/test_cmp_ctrl_top.sv
module test_cmp_ctrl_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       cmp_async;
  logic       wr_en;
  logic [0:0] wr_addr;
  logic [7:0] wr_data;
  logic       cmp_en, cmp_level, rise_flag, fall_flag, irq, wake_req;
  logic [1:0] hyst_pos, hyst_neg, resp_mode;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cmp_ctrl_top i_cmp_ctrl_top (
    .clk       (clk),
    .rst       (rst),
    .cmp_async (cmp_async),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .cmp_en    (cmp_en),
    .hyst_pos  (hyst_pos),
    .hyst_neg  (hyst_neg),
    .resp_mode (resp_mode),
    .cmp_level (cmp_level),
    .rise_flag (rise_flag),
    .fall_flag (fall_flag),
    .irq       (irq),
    .wake_req  (wake_req)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cmp_async = 1'b0; wr_en = 1'b0; wr_addr = 1'b0; wr_data = 8'h00;
    step(3);
    rst = 1'b0;
    step(1);
    // reset state
    chk("R6", "reset cmp_en", cmp_en, 0);
    chk("R3", "reset flags", {rise_flag, fall_flag}, 0);
    chk("R10", "reset irq", irq, 0);
    chk("R7", "reset wake", wake_req, 0);
    chk("R8", "reset hyst", {hyst_pos, hyst_neg}, 0);

    // R8/R7 sweep: every hysteresis code pair with enable off and on, level low
    for (int e = 0; e < 2; e++)
      for (int p = 0; p < 4; p++)
        for (int n = 0; n < 4; n++) begin
          wr(1'b0, 8'((e << 7) | 8'h30 | (p << 2) | n));
          chk("R8", "hyst_pos", hyst_pos, p);
          chk("R8", "hyst_neg", hyst_neg, n);
          chk("R6", "cmp_en", cmp_en, e);
          step(1);
          chk("R7", "wake with level low", wake_req, e);
        end

    // R9 sweep: response code and interrupt enables
    for (int ie = 0; ie < 4; ie++)
      for (int m = 0; m < 4; m++) begin
        wr(1'b1, 8'((ie << 4) | m));
        chk("R9", "resp_mode", resp_mode, m);
      end
    chk("R8", "hyst kept across mode writes", {hyst_pos, hyst_neg}, 4'hF);

    // disable, then raise the input: no flag, level still visible
    wr(1'b0, 8'h30);
    wr(1'b1, 8'h30);
    cmp_async = 1'b1;
    step(1);
    chk("R5", "level after one edge", cmp_level, 0);
    step(1);
    chk("R5", "level after two edges", cmp_level, 1);
    step(2);
    chk("R6", "no rise flag while disabled", rise_flag, 0);
    chk("R7", "no wake while disabled", wake_req, 0);

    // enable with level already high: no false edge
    wr(1'b0, 8'hB0);
    step(3);
    chk("R6", "no false edge on enable", {rise_flag, fall_flag}, 0);
    chk("R7", "no wake with level high", wake_req, 0);

    // falling edge
    cmp_async = 1'b0;
    step(2);
    chk("R5", "level low", cmp_level, 0);
    chk("R1", "fall not early", fall_flag, 0);
    step(1);
    chk("R1", "fall flag set", fall_flag, 1);
    chk("R7", "wake with level low", wake_req, 1);
    chk("R10", "irq not early", irq, 0);
    step(1);
    chk("R10", "irq from fall", irq, 1);

    // rising edge
    cmp_async = 1'b1;
    step(2);
    chk("R2", "rise not early", rise_flag, 0);
    step(1);
    chk("R2", "rise flag set", rise_flag, 1);
    chk("R3", "fall flag stays", fall_flag, 1);
    chk("R7", "wake drops", wake_req, 0);

    // writing 1s leaves flags
    wr(1'b0, 8'hB0);
    chk("R3", "write 1 keeps flags", {rise_flag, fall_flag}, 3);
    // clear rise only
    wr(1'b0, 8'h90);
    chk("R3", "rise cleared", rise_flag, 0);
    chk("R3", "fall kept", fall_flag, 1);
    step(1);
    chk("R10", "irq from fall only", irq, 1);
    wr(1'b1, 8'h20);
    step(1);
    chk("R10", "irq masked", irq, 0);
    wr(1'b0, 8'hA0);
    chk("R3", "fall cleared", fall_flag, 0);
    wr(1'b1, 8'h30);

    // same-cycle clear and new edge
    cmp_async = 1'b0;
    step(3);
    chk("R1", "fall set again", fall_flag, 1);
    cmp_async = 1'b1;
    step(2);
    wr(1'b0, 8'h80);
    chk("R4", "rise edge beats clear", rise_flag, 1);
    chk("R3", "fall cleared with it", fall_flag, 0);
    step(1);
    chk("R10", "irq from rise", irq, 1);

    // disable with flags kept; toggling sets nothing new
    wr(1'b0, 8'h30);
    cmp_async = 1'b0;
    step(4);
    cmp_async = 1'b1;
    step(4);
    chk("R6", "no fall while disabled", fall_flag, 0);
    chk("R3", "rise sticky while disabled", rise_flag, 1);
    chk("R5", "level tracks while disabled", cmp_level, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule